// File: doc/BRIEF.md
# Interrupt-capable general-purpose I/O port

This block is a bank of general-purpose pins behind a small memory-mapped register interface on an APB-style bus. Software chooses, pin by pin, whether the pin is driven and with which value, and can read back the synchronized level of every pin at any time. Each pin can also raise an interrupt. Two independent per-pin bits select the trigger: one picks level or edge sensitivity, the other picks the active sense (low/falling or high/rising).

Edge events are captured in a sticky per-pin latch that stays set until software writes a one to that pin's bit in the clear register. Level interrupts have no latch and follow the pin. A per-pin enable gates detection, a per-pin mask hides pins from the processor line, and both the unmasked and masked status words can be read. An optional per-pin debounce filter accepts a new input level only after it has held for a set number of slow tick pulses. A control bit adds one register stage to the level path, so that level status is aligned to the bus clock.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every readable register (offsets 0x00 to 0x60) reads zero, `pins_oe` and `pins_out` are zero and `irq` is low.
- R2: `pins_out` equals the output value register (0x00) and `pins_oe` equals the direction register (0x04), where a 1 bit makes the pin an output; both follow a write on the next clock.
- R3: Offset 0x50 returns the two-flop-synchronized level of every pin, whatever its direction.
- R4: Trigger type is set per pin by the type bit (0x38; 0 level, 1 edge) and the sense bit (0x3C; 0 low/falling, 1 high/rising), so {sense,type} = 00 low level, 10 high level, 01 falling edge, 11 rising edge; a level pin's raw status follows the pin.
- R5: An edge latch stays set until a 1 is written to its bit at offset 0x4C; a 0 bit there has no effect, the offset reads zero, and an edge arriving in the clearing cycle wins.
- R6: A pin whose enable bit (0x30) is 0 never shows raw status and sets no edge latch.
- R7: Masked status (0x40) equals raw status (0x44) with bits set in the mask register (0x34) cleared, and `irq` is the OR of masked status.
- R8: With a pin's debounce bit (0x48) set, a changed input is accepted only after it has differed from the accepted value across DB_TICKS consecutive `db_tick` pulses; a return to the accepted value restarts the count.
- R9: Bit 0 of offset 0x60 set adds exactly one clock of delay between the synchronized pin and level-sensitive status.
- R10: Writes to undefined offsets and to the read-only offsets 0x40, 0x44 and 0x50 change no state; undefined offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| pins_in | input | NPINS | Raw pad levels |
| pins_out | output | NPINS | Values driven to the pads |
| pins_oe | output | NPINS | Per-pin output enable |
| db_tick | input | 1 | Slow tick pulse for the debounce filter |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench builds the block with its defaults, 32 pins and a debounce window of 4 ticks, so every bit of every register and the full 32-bit status word are exercised by random pin patterns and configurations. A window of 4 keeps the debounce boundary (three ticks rejected, the fourth accepted, a glitch restarting the count) within a few dozen cycles. Directed cycle-exact checks on the interrupt line cover the extra level-path stage.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned BUS_W = 32;

    localparam logic [7:0] OFF_DOUT  = 8'h00;
    localparam logic [7:0] OFF_DIR   = 8'h04;
    localparam logic [7:0] OFF_IEN   = 8'h30;
    localparam logic [7:0] OFF_IMASK = 8'h34;
    localparam logic [7:0] OFF_ITYPE = 8'h38;
    localparam logic [7:0] OFF_IPOL  = 8'h3C;
    localparam logic [7:0] OFF_MSTAT = 8'h40;
    localparam logic [7:0] OFF_RSTAT = 8'h44;
    localparam logic [7:0] OFF_DBEN  = 8'h48;
    localparam logic [7:0] OFF_CLR   = 8'h4C;
    localparam logic [7:0] OFF_PINS  = 8'h50;
    localparam logic [7:0] OFF_LSYNC = 8'h60;
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int unsigned NPINS    = 32,
    parameter int unsigned DB_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_in,
    input  logic [NPINS-1:0] dben,
    input  logic             db_tick,
    output logic [NPINS-1:0] synced,
    output logic [NPINS-1:0] filt
);
    localparam int unsigned CW = $clog2(DB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          acc;
        logic [CW-1:0] cnt;
    } pin_st_t;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_st_t st_d, st_q;

        always_comb begin
            st_d    = st_q;
            st_d.s1 = pins_in[i];
            st_d.s2 = st_q.s1;
            if (!dben[i]) begin
                st_d.acc = st_q.s2;
                st_d.cnt = '0;
            end else if (st_q.s2 == st_q.acc) begin
                st_d.cnt = '0;
            end else if (db_tick) begin
                if (st_q.cnt == LAST) begin
                    st_d.acc = st_q.s2;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign synced[i] = st_q.s2;
        assign filt[i]   = dben[i] ? st_q.acc : st_q.s2;

        // R8: a debounced pin's accepted level moves only on a tick
        p_db_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (dben[i] && !db_tick) |=> $stable(st_q.acc));
    end
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] filt,
    input  logic [NPINS-1:0] ien,
    input  logic [NPINS-1:0] itype,
    input  logic [NPINS-1:0] ipol,
    input  logic [NPINS-1:0] imask,
    input  logic             lsync,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_bits,
    output logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] masked,
    output logic             irq
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] latch;
        logic [NPINS-1:0] lvl;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [NPINS-1:0] rise, fall, edge_set, lvl_act, lvl_use;

    always_comb begin
        rise     = filt & ~st_q.prev;
        fall     = ~filt & st_q.prev;
        edge_set = ien & itype & ((ipol & rise) | (~ipol & fall));
        lvl_act  = ~itype & ~(filt ^ ipol);
        lvl_use  = lsync ? st_q.lvl : lvl_act;

        st_d       = st_q;
        st_d.prev  = filt;
        st_d.lvl   = lvl_act;
        st_d.latch = (st_q.latch & ~(clr_we ? clr_bits : '0)) | edge_set;

        raw    = ien & ((itype & st_q.latch) | (~itype & lvl_use));
        masked = raw & ~imask;
        irq    = |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a written 1 clears the latch unless a new edge arrived with it
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((st_q.latch & $past(clr_bits) & ~$past(edge_set)) == '0));
    // R5: without a clear write no latched edge is ever lost
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(st_q.latch) & ~st_q.latch) == '0));
    // R6: a disabled pin never sets its latch
    p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.latch & ~$past(st_q.latch) & ~$past(ien)) == '0));
endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    input  logic [NPINS-1:0]  raw,
    input  logic [NPINS-1:0]  masked,
    input  logic [NPINS-1:0]  synced,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  imask,
    output logic [NPINS-1:0]  itype,
    output logic [NPINS-1:0]  ipol,
    output logic [NPINS-1:0]  dben,
    output logic              lsync,
    output logic              clr_we,
    output logic [NPINS-1:0]  clr_bits
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] imask;
        logic [NPINS-1:0] itype;
        logic [NPINS-1:0] ipol;
        logic [NPINS-1:0] dben;
        logic             lsync;
    } csr_st_t;

    csr_st_t st_d, st_q;
    logic             wr;
    logic [7:0]       off;
    logic [NPINS-1:0] wd;
    logic             known;

    assign off = 8'(paddr);
    assign wd  = pwdata[NPINS-1:0];
    assign wr  = psel & penable & pwrite;

    always_comb begin
        st_d   = st_q;
        clr_we = 1'b0;
        if (wr) begin
            case (off)
                OFF_DOUT:  st_d.dout  = wd;
                OFF_DIR:   st_d.dir   = wd;
                OFF_IEN:   st_d.ien   = wd;
                OFF_IMASK: st_d.imask = wd;
                OFF_ITYPE: st_d.itype = wd;
                OFF_IPOL:  st_d.ipol  = wd;
                OFF_DBEN:  st_d.dben  = wd;
                OFF_LSYNC: st_d.lsync = pwdata[0];
                OFF_CLR:   clr_we     = 1'b1;
                default:   ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        known  = 1'b1;
        case (off)
            OFF_DOUT:  prdata = BUS_W'(st_q.dout);
            OFF_DIR:   prdata = BUS_W'(st_q.dir);
            OFF_IEN:   prdata = BUS_W'(st_q.ien);
            OFF_IMASK: prdata = BUS_W'(st_q.imask);
            OFF_ITYPE: prdata = BUS_W'(st_q.itype);
            OFF_IPOL:  prdata = BUS_W'(st_q.ipol);
            OFF_MSTAT: prdata = BUS_W'(masked);
            OFF_RSTAT: prdata = BUS_W'(raw);
            OFF_DBEN:  prdata = BUS_W'(st_q.dben);
            OFF_CLR:   prdata = '0;
            OFF_PINS:  prdata = BUS_W'(synced);
            OFF_LSYNC: prdata = BUS_W'(st_q.lsync);
            default:   known  = 1'b0;
        endcase
        if (!psel) prdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout     = st_q.dout;
    assign dir      = st_q.dir;
    assign ien      = st_q.ien;
    assign imask    = st_q.imask;
    assign itype    = st_q.itype;
    assign ipol     = st_q.ipol;
    assign dben     = st_q.dben;
    assign lsync    = st_q.lsync;
    assign clr_bits = wd;

    // R2: a direction write reaches the output enables on the next clock
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_DIR) |=> (dir == $past(wd)));
    // R10: writes to unknown or read-only offsets leave every register alone
    p_ignore_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (!known || off == OFF_MSTAT || off == OFF_RSTAT || off == OFF_PINS))
        |=> (st_q == $past(st_q)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS    = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DB_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NPINS-1:0]  pins_in,
    output logic [NPINS-1:0]  pins_out,
    output logic [NPINS-1:0]  pins_oe,
    input  logic              db_tick,
    output logic              irq
);
    logic [NPINS-1:0] ien, imask, itype, ipol, dben, clr_bits;
    logic [NPINS-1:0] raw, masked, synced, filt;
    logic             lsync, clr_we;

    gpio_csr #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .raw(raw), .masked(masked), .synced(synced),
        .dout(pins_out), .dir(pins_oe), .ien(ien), .imask(imask),
        .itype(itype), .ipol(ipol), .dben(dben), .lsync(lsync),
        .clr_we(clr_we), .clr_bits(clr_bits)
    );

    gpio_in_filter #(.NPINS(NPINS), .DB_TICKS(DB_TICKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .dben(dben),
        .db_tick(db_tick), .synced(synced), .filt(filt)
    );

    gpio_irq_core #(.NPINS(NPINS)) u_core (
        .clk(clk), .rst_n(rst_n), .filt(filt), .ien(ien), .itype(itype),
        .ipol(ipol), .imask(imask), .lsync(lsync), .clr_we(clr_we),
        .clr_bits(clr_bits), .raw(raw), .masked(masked), .irq(irq)
    );
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    localparam int unsigned NP = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NP-1:0] pins_in = '0;
    logic [NP-1:0] pins_out, pins_oe;
    logic        db_tick = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
        .db_tick(db_tick), .irq(irq)
    );

    // bench model state
    logic [NP-1:0] m_en, m_mask, m_type, m_pol, m_latch, m_pin;

    function automatic logic [NP-1:0] exp_raw();
        return m_en & ((m_type & m_latch) | (~m_type & ~(m_pin ^ m_pol)));
    endfunction

    function automatic logic [NP-1:0] edge_hits(logic [NP-1:0] o, logic [NP-1:0] n);
        return m_en & m_type & ((m_pol & ~o & n) | (~m_pol & o & ~n));
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic tick_pulse();
        @(negedge clk); db_tick = 1'b1;
        @(negedge clk); db_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v, d;
        logic [NP-1:0] clr, np;
        logic [7:0] offs [12];
        void'($urandom(32'h5EED_0042));
        offs = '{8'h00, 8'h04, 8'h30, 8'h34, 8'h38, 8'h3C,
                 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h60};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state (pins low, all config zero -> low-level trigger, but enable is zero)
        #1;
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 oe", pins_oe, 32'h0);
        check("R1 out", pins_out, 32'h0);
        foreach (offs[i]) begin
            rd(offs[i], v);
            check("R1 reg", v, 32'h0);
        end

        // R2: data and direction drive the pad outputs
        wr(8'h00, 32'hA5A5_0F0F);
        wr(8'h04, 32'h00FF_FF00);
        #1;
        check("R2 out", pins_out, 32'hA5A5_0F0F);
        check("R2 oe", pins_oe, 32'h00FF_FF00);

        // R3: pin levels are readable regardless of direction
        pins_in = 32'h1234_5678;
        idle(3);
        rd(8'h50, v);
        check("R3 pins", v, 32'h1234_5678);
        pins_in = '0;
        idle(3);

        // R9: level-sync bit adds one clock on the level path
        wr(8'h38, 32'h0);
        wr(8'h3C, 32'h2);
        wr(8'h34, 32'h0);
        wr(8'h60, 32'h1);
        wr(8'h30, 32'h2);
        idle(4);
        @(negedge clk) pins_in[1] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R9 sync on, 2 clocks", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R9 sync on, 3 clocks", {31'b0, irq}, 32'h1);
        @(negedge clk) pins_in[1] = 1'b0;
        idle(4);
        wr(8'h60, 32'h0);
        idle(2);
        @(negedge clk) pins_in[1] = 1'b1;
        @(posedge clk); #1;
        check("R9 sync off, 1 clock", {31'b0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R9 sync off, 2 clocks", {31'b0, irq}, 32'h1);
        @(negedge clk) pins_in[1] = 1'b0;
        wr(8'h30, 32'h0);
        idle(4);

        // R8: debounce on pin 0, rising edge
        wr(8'h48, 32'h1);
        wr(8'h38, 32'h1);
        wr(8'h3C, 32'h1);
        wr(8'h30, 32'h1);
        idle(4);
        pins_in[0] = 1'b1;
        idle(4);
        tick_pulse(); tick_pulse();
        pins_in[0] = 1'b0;           // glitch back restarts the count
        idle(4);
        pins_in[0] = 1'b1;
        idle(4);
        tick_pulse(); tick_pulse(); tick_pulse();
        idle(4);
        rd(8'h44, v);
        check("R8 three ticks rejected", v, 32'h0);
        rd(8'h50, v);
        check("R3 pins bypass debounce", v, 32'h1);
        tick_pulse();
        idle(4);
        rd(8'h44, v);
        check("R8 fourth tick accepted", v, 32'h1);
        // R5: writing 0 does nothing, writing 1 clears, clear reads zero
        wr(8'h4C, 32'hFFFF_FFFE);
        rd(8'h44, v);
        check("R5 zero bit no effect", v, 32'h1);
        wr(8'h4C, 32'h1);
        rd(8'h44, v);
        check("R5 one bit clears", v, 32'h0);
        rd(8'h4C, v);
        check("R5 reads zero", v, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h48, 32'h0);
        pins_in = '0;
        idle(4);

        // R10: undefined and read-only writes change nothing
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h10, v);
        check("R10 undefined reads zero", v, 32'h0);
        rd(8'h30, v);
        check("R10 enable untouched", v, 32'h0);
        rd(8'h04, v);
        check("R10 direction untouched", v, 32'h00FF_FF00);
        rd(8'h44, v);
        check("R10 raw stays zero", v, 32'h0);

        // Random: R4, R5, R6, R7
        m_latch = '0;
        m_pin = '0;
        m_en = '0; m_type = '0; m_pol = '0; m_mask = '0;
        for (int it = 0; it < 300; it++) begin
            m_en = $urandom; m_type = $urandom; m_pol = $urandom; m_mask = $urandom;
            wr(8'h38, m_type);
            wr(8'h3C, m_pol);
            wr(8'h34, m_mask);
            wr(8'h30, m_en);
            wr(8'h60, {31'b0, 1'($urandom)});
            np = (it % 4 == 0) ? ~m_pin : $urandom;
            m_latch = m_latch | edge_hits(m_pin, np);
            m_pin = np;
            pins_in = np;
            idle(6);
            rd(8'h44, v);
            check("R4 R6 raw status", v, exp_raw());
            rd(8'h40, d);
            check("R7 masked status", d, exp_raw() & ~m_mask);
            #1;
            check("R7 irq line", {31'b0, irq}, {31'b0, |(exp_raw() & ~m_mask)});
            clr = $urandom;
            wr(8'h4C, clr);
            m_latch = m_latch & ~clr;
            rd(8'h44, v);
            check("R5 raw after clear", v, exp_raw());
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule